// File: doc/BRIEF.md
# Skip-Capable Execute Unit

This block is the execute slice of a small 8-bit processor. It fetches 16-bit words from a program ROM and executes two operations. The first tests a banked file register and skips on zero. The second exclusive-ORs an 8-bit literal into the working register W. Every instruction cycle spans four clocks, one per phase: decode, operand read, process, write. The next word is fetched during the last phase of the current cycle.

When a test finds zero, the word already prefetched is discarded and its cycle runs as a bubble. If that discarded word opens a two-word instruction, the word after it is discarded too. A skip therefore costs one or two extra instruction cycles.

The register address is built from one of three sources: the access bank, a bank chosen by the bank select input, or an index base plus the literal when extended mode is on.

Top module: `skx_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears the program counter, W, N, Z and the phase counter. The first instruction cycle after reset is a bubble (exec_slot low) that fetches word 0.
- R2: The phase output steps 0,1,2,3 and wraps. rom_addr holds steady during phases 0 to 2 and advances by one on the clock that ends phase 3, which is when the next word is captured.
- R3: Word 0x0A kk sets W to W XOR kk at the end of phase 3, with N = bit 7 of the result and Z = (result == 0x00), in a single cycle. For example, 0xB5 XOR 0xAF gives 0x1A.
- R4: Word 0b0110011a ffffffff that reads zero from its register causes the next instruction cycle to run with exec_slot low, so its word has no effect.
- R5: The same test reading a nonzero value lets the next word execute normally.
- R6: When a discarded word has top nibble 0xC or 0xE, the following word is discarded as well, for three cycles in total.
- R7: The test-and-skip leaves W, N and Z unchanged.
- R8: With a = 1 (word bit 8), the register address is {bank_sel, f}.
- R9: With a = 0 and extended mode off, addresses f < 0x60 map to 0x000+f and f >= 0x60 map to 0xF00+f.
- R10: With a = 0, extended mode on and f <= 0x5F, the address is (index_base + f) mod 4096. Higher f still uses the access mapping of R9.
- R11: Every other word, including a non-discarded two-word instruction, runs as a one-cycle no-operation that leaves W, N and Z unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | 8 | Program counter, program ROM read address |
| rom_data | input | 16 | Program ROM word at rom_addr (combinational read) |
| rf_addr | output | 12 | Register file read address |
| rf_data | input | 8 | Register file byte at rf_addr |
| bank_sel | input | 4 | Bank select value |
| ext_mode | input | 1 | Enables indexed literal offset addressing |
| index_base | input | 12 | Base address for indexed literal offset mode |
| w_reg | output | 8 | Working register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| phase | output | 2 | Current phase of the instruction cycle |
| exec_slot | output | 1 | High when the current cycle's word executes, low for a discarded word |

## Verification
A wrong discard flag shows up within one instruction cycle, at most four clocks. It appears as exec_slot disagreeing with the model, and a discarded XOR that wrongly executes changes w_reg at the next phase-3 edge. A bad address mux shows on rf_addr during phase 1 of the test instruction. A bad operand latch instead surfaces one cycle later, as a missing or extra bubble. Errors in the program counter or phase counter show on rom_addr or phase at the very next clock.

// File: rtl/skx_pkg.sv
`timescale 1ns/1ps
package skx_pkg;
   typedef enum logic [1:0] {
      PH_DECODE = 2'd0,
      PH_READ   = 2'd1,
      PH_PROC   = 2'd2,
      PH_WRITE  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      OP_NOP     = 2'd0,
      OP_XORLIT  = 2'd1,
      OP_TSTSKIP = 2'd2
   } op_e;

   typedef struct packed {
      op_e        op;
      logic       bank_bit;
      logic [7:0] fld;
      logic       two_word;
   } dec_s;
endpackage

// File: rtl/skx_decode.sv
`timescale 1ns/1ps
module skx_decode
   import skx_pkg::*;
#(
   parameter int         INSN_W   = 16,
   parameter logic [7:0] XOR_OPC  = 8'h0A,
   parameter logic [6:0] TST_OPC  = 7'b0110011,
   parameter logic [3:0] LONG_A   = 4'hC,
   parameter logic [3:0] LONG_B   = 4'hE
) (
   input  logic [INSN_W-1:0] word,
   output dec_s              dec
);
   localparam int TOP = INSN_W - 1;

   generate
      if (INSN_W != 16) begin : g_bad_width
         $error("skx_decode: INSN_W must be 16");
      end
   endgenerate

   always_comb begin
      dec          = '0;
      dec.fld      = word[7:0];
      dec.bank_bit = word[8];
      dec.two_word = (word[TOP -: 4] == LONG_A) || (word[TOP -: 4] == LONG_B);
      if (word[TOP -: 8] == XOR_OPC)
         dec.op = OP_XORLIT;
      else if (word[TOP -: 7] == TST_OPC)
         dec.op = OP_TSTSKIP;
      else
         dec.op = OP_NOP;
   end
endmodule

// File: rtl/skx_addr_gen.sv
`timescale 1ns/1ps
module skx_addr_gen #(
   parameter int              DATA_W    = 8,
   parameter int              BANK_W    = 4,
   parameter int              ADDR_W    = BANK_W + DATA_W,
   parameter logic [DATA_W-1:0] ACC_SPLIT = 8'h60,
   parameter bit              EXT_EN    = 1'b1
) (
   input  logic              bank_bit,
   input  logic [DATA_W-1:0] fld,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic              ext_mode,
   input  logic [ADDR_W-1:0] index_base,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [BANK_W-1:0] LOW_BANK  = '0;
   localparam logic [BANK_W-1:0] HIGH_BANK = '1;

   generate
      if (ADDR_W != BANK_W + DATA_W) begin : g_bad_addr
         $error("skx_addr_gen: ADDR_W must equal BANK_W + DATA_W");
      end
   endgenerate

   logic [ADDR_W-1:0] access_addr;
   logic              use_index;

   assign access_addr = (fld < ACC_SPLIT) ? {LOW_BANK, fld} : {HIGH_BANK, fld};

   generate
      if (EXT_EN) begin : g_ext
         assign use_index = ext_mode && (fld < ACC_SPLIT);
      end else begin : g_no_ext
         logic unused_ext;
         assign unused_ext = ext_mode ^ (^index_base);
         assign use_index  = 1'b0;
      end
   endgenerate

   always_comb begin
      if (bank_bit)
         addr = {bank_sel, fld};
      else if (use_index)
         addr = index_base + {{BANK_W{1'b0}}, fld};
      else
         addr = access_addr;
   end

   // R9: low half of access bank stays in bank 0 unless indexing applies
   always_comb begin
      if (!bank_bit && !ext_mode && (fld < ACC_SPLIT))
         p_acc_low_r9: assert (addr[ADDR_W-1 -: BANK_W] == LOW_BANK);
   end
endmodule

// File: rtl/skx_alu.sv
`timescale 1ns/1ps
module skx_alu #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] w_in,
   input  logic [DATA_W-1:0] lit,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] xor_res,
   output logic              res_neg,
   output logic              res_zero,
   output logic              opnd_zero
);
   assign xor_res   = w_in ^ lit;
   assign res_neg   = xor_res[DATA_W-1];
   assign res_zero  = (xor_res == '0);
   assign opnd_zero = (opnd == '0);
endmodule

// File: rtl/skx_exec_unit.sv
`timescale 1ns/1ps
module skx_exec_unit
   import skx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BANK_W = 4,
   parameter int PC_W   = 8,
   parameter int INSN_W = 16,
   parameter bit EXT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [PC_W-1:0]   rom_addr,
   input  logic [INSN_W-1:0] rom_data,
   output logic [BANK_W+DATA_W-1:0] rf_addr,
   input  logic [DATA_W-1:0] rf_data,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic              ext_mode,
   input  logic [BANK_W+DATA_W-1:0] index_base,
   output logic [DATA_W-1:0] w_reg,
   output logic              flag_n,
   output logic              flag_z,
   output logic [1:0]        phase,
   output logic              exec_slot
);
   localparam int ADDR_W = BANK_W + DATA_W;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("skx_exec_unit: DATA_W must be 8");
      end
      if (PC_W < 2) begin : g_bad_pc
         $error("skx_exec_unit: PC_W too small");
      end
   endgenerate

   logic [1:0]        phase_q;
   logic [PC_W-1:0]   pc_q;
   logic [INSN_W-1:0] ir_q;
   logic              disc_q;
   logic [DATA_W-1:0] w_q, opnd_q, res_q;
   logic              n_q, z_q, res_n_q, res_z_q, opz_q;

   dec_s              dec;
   logic [DATA_W-1:0] xor_res;
   logic              res_neg, res_zero, opnd_zero;
   logic              skip_now;

   skx_decode #(.INSN_W(INSN_W)) u_dec (
      .word (ir_q),
      .dec  (dec)
   );

   skx_addr_gen #(
      .DATA_W (DATA_W),
      .BANK_W (BANK_W),
      .ADDR_W (ADDR_W),
      .EXT_EN (EXT_EN)
   ) u_addr (
      .bank_bit   (dec.bank_bit),
      .fld        (dec.fld),
      .bank_sel   (bank_sel),
      .ext_mode   (ext_mode),
      .index_base (index_base),
      .addr       (rf_addr)
   );

   skx_alu #(.DATA_W(DATA_W)) u_alu (
      .w_in      (w_q),
      .lit       (dec.fld),
      .opnd      (opnd_q),
      .xor_res   (xor_res),
      .res_neg   (res_neg),
      .res_zero  (res_zero),
      .opnd_zero (opnd_zero)
   );

   assign skip_now = !disc_q && (dec.op == OP_TSTSKIP) && opz_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= 2'd0;
         pc_q    <= '0;
         ir_q    <= '0;
         disc_q  <= 1'b1;
         w_q     <= '0;
         n_q     <= 1'b0;
         z_q     <= 1'b0;
         opnd_q  <= '0;
         res_q   <= '0;
         res_n_q <= 1'b0;
         res_z_q <= 1'b0;
         opz_q   <= 1'b0;
      end else begin
         phase_q <= phase_q + 2'd1;
         case (phase_q)
            PH_READ: opnd_q <= rf_data;
            PH_PROC: begin
               res_q   <= xor_res;
               res_n_q <= res_neg;
               res_z_q <= res_zero;
               opz_q   <= opnd_zero;
            end
            PH_WRITE: begin
               if (!disc_q && (dec.op == OP_XORLIT)) begin
                  w_q <= res_q;
                  n_q <= res_n_q;
                  z_q <= res_z_q;
               end
               ir_q   <= rom_data;
               pc_q   <= pc_q + {{(PC_W-1){1'b0}}, 1'b1};
               disc_q <= skip_now || (disc_q && dec.two_word);
            end
            default: ;
         endcase
      end
   end

   assign rom_addr  = pc_q;
   assign w_reg     = w_q;
   assign flag_n    = n_q;
   assign flag_z    = z_q;
   assign phase     = phase_q;
   assign exec_slot = !disc_q;

   // R2: phases advance one per clock
   p_phase_seq_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> phase_q == $past(phase_q) + 2'd1);
   // R2: PC moves only at end of write phase
   p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (phase_q != 2'd3) |=> $stable(pc_q));
   p_pc_adv_r2: assert property (@(posedge clk) disable iff (rst)
      (phase_q == 2'd3) |=> pc_q == $past(pc_q) + {{(PC_W-1){1'b0}}, 1'b1});
   // R3: W only written at the end of the write phase
   p_w_window_r3: assert property (@(posedge clk) disable iff (rst)
      (phase_q != 2'd3) |=> $stable(w_q));
   // R3: flags agree with the new W after an XOR
   p_flags_r3: assert property (@(posedge clk) disable iff (rst)
      (phase_q == 2'd3 && !disc_q && dec.op == OP_XORLIT)
      |=> (z_q == (w_q == '0)) && (n_q == w_q[DATA_W-1]));
   // R4: zero operand on a live test discards the next word
   p_skip_r4: assert property (@(posedge clk) disable iff (rst)
      (phase_q == 2'd3 && !disc_q && dec.op == OP_TSTSKIP && opnd_q == '0)
      |=> !exec_slot);
   // R7: test-and-skip leaves W and flags alone
   p_tst_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      (phase_q == 2'd3 && dec.op == OP_TSTSKIP)
      |=> $stable(w_q) && $stable(n_q) && $stable(z_q));
   // R8: banked access uses bank_sel as upper address bits
   p_bank_r8: assert property (@(posedge clk) disable iff (rst)
      dec.bank_bit |-> rf_addr[ADDR_W-1 -: BANK_W] == bank_sel);
   // R11: other words do not touch W
   p_nop_quiet_r11: assert property (@(posedge clk) disable iff (rst)
      (phase_q == 2'd3 && dec.op == OP_NOP) |=> $stable(w_q));
endmodule

// File: tb/tb_skx_exec_unit.sv
`timescale 1ns/1ps
module tb_skx_exec_unit;
   logic        clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst = 1'b1;
   logic [7:0]  rom_addr;
   logic [15:0] rom_data;
   logic [11:0] rf_addr;
   logic [7:0]  rf_data;
   logic [3:0]  bank_sel = 4'd3;
   logic        ext_mode = 1'b0;
   logic [11:0] index_base = '0;
   logic [7:0]  w;
   logic        fn, fz;
   logic [1:0]  phase;
   logic        exec_slot;

   logic [15:0] rom [256];
   logic [7:0]  mem [4096];

   assign rom_data = rom[rom_addr];
   assign rf_data  = mem[rf_addr];

   skx_exec_unit dut (
      .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
      .rf_addr(rf_addr), .rf_data(rf_data), .bank_sel(bank_sel),
      .ext_mode(ext_mode), .index_base(index_base), .w_reg(w),
      .flag_n(fn), .flag_z(fz), .phase(phase), .exec_slot(exec_slot)
   );

   int n_cmp = 0, n_bad = 0;
   int m_phase, m_pc, m_w, m_n, m_z, m_ir, m_disc;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int maddr(int word);
      int f, a;
      f = word & 255;
      a = (word >> 8) & 1;
      if (a == 1) return int'(bank_sel) * 256 + f;
      if (ext_mode && f <= 'h5F) return (int'(index_base) + f) & 'hFFF;
      if (f < 'h60) return f;
      return 'hF00 + f;
   endfunction

   function automatic string addr_tag(int word);
      if (((word >> 8) & 1) == 1) return "R8 banked rf_addr";
      if (ext_mode && (word & 255) <= 'h5F) return "R10 indexed rf_addr";
      return "R9 access rf_addr";
   endfunction

   task automatic mreset();
      m_phase = 0; m_pc = 0; m_w = 0; m_n = 0; m_z = 0; m_ir = 0; m_disc = 1;
   endtask

   task automatic mstep();
      int op;
      bit sk, tw;
      if (m_phase == 3) begin
         op = m_ir;
         sk = 1'b0;
         if (m_disc == 0 && ((op >> 8) & 255) == 'h0A) begin
            m_w = (m_w ^ (op & 255)) & 255;
            m_n = (m_w >> 7) & 1;
            m_z = (m_w == 0) ? 1 : 0;
         end
         if (m_disc == 0 && ((op >> 9) & 127) == 'h33 && mem[maddr(op)] == 8'h00)
            sk = 1'b1;
         tw = (((op >> 12) & 15) == 'hC) || (((op >> 12) & 15) == 'hE);
         m_disc = (sk || (m_disc == 1 && tw)) ? 1 : 0;
         m_ir = int'(rom[m_pc]);
         m_pc = (m_pc + 1) & 255;
      end
      m_phase = (m_phase + 1) & 3;
   endtask

   task automatic compare();
      chk("R2 phase", 32'(phase), 32'(m_phase));
      chk("R2 rom_addr", 32'(rom_addr), 32'(m_pc));
      chk("R3 R7 R11 W", 32'(w), 32'(m_w));
      chk("R3 flag N", 32'(fn), 32'(m_n));
      chk("R3 flag Z", 32'(fz), 32'(m_z));
      chk("R4 R5 R6 R11 exec_slot", 32'(exec_slot), 32'(m_disc == 0));
      if (m_phase == 1 && m_disc == 0 && ((m_ir >> 9) & 127) == 'h33)
         chk(addr_tag(m_ir), 32'(rf_addr), 32'(maddr(m_ir)));
   endtask

   task automatic run(bit ext, logic [11:0] ib);
      ext_mode   = ext;
      index_base = ib;
      bank_sel   = 4'd3;
      rst        = 1'b1;
      repeat (3) @(negedge clk);
      mreset();
      // R1: reset state
      chk("R1 rom_addr", 32'(rom_addr), 0);
      chk("R1 W", 32'(w), 0);
      chk("R1 flags", 32'({fn, fz}), 0);
      chk("R1 phase", 32'(phase), 0);
      chk("R1 bubble", 32'(exec_slot), 0);
      rst = 1'b0;
      for (int s = 1; s <= 120; s++) begin
         @(negedge clk);
         mstep();
         compare();
         if (s == 12 && !ext) chk("R3 literal B5^AF", 32'(w), 32'h1A);
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 1);
      rom[0]  = 16'h0AB5;  rom[1]  = 16'h0AAF;  rom[2]  = 16'h6610;
      rom[3]  = 16'h0AFF;  rom[4]  = 16'h6720;  rom[5]  = 16'h0A01;
      rom[6]  = 16'h6670;  rom[7]  = 16'hC000;  rom[8]  = 16'hF000;
      rom[9]  = 16'h0A80;  rom[10] = 16'h0A9B;  rom[11] = 16'h1234;
      rom[12] = 16'hE000;  rom[13] = 16'hF000;  rom[14] = 16'h6605;
      rom[15] = 16'h0A11;  rom[16] = 16'h6705;  rom[17] = 16'h0A22;
      rom[18] = 16'h66A0;  rom[19] = 16'h0A44;
      mem['h010] = 8'h00;  mem['h320] = 8'h05;  mem['hF70] = 8'h00;
      mem['h005] = 8'h07;  mem['h205] = 8'h00;  mem['h210] = 8'h09;
      mem['h305] = 8'h00;  mem['hFA0] = 8'h03;
      run(1'b0, 12'h000);
      run(1'b1, 12'h200);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule